// File: doc/BRIEF.md
# Write Protection Guard for a Serial Nonvolatile Memory

This block decides, cycle by cycle, whether a write requested by the serial slave controller may go ahead. It covers writes into the data array and writes into the status register. It owns two pieces of state. The first is the write enable latch, which must be armed before any write. The second is a pair of block-protect bits. These bits fence off nothing, the top quarter, the top half, or the whole of the 14-bit address space. A hardwired active-low write-protect pin can freeze the protect bits by refusing every status-register write while it is held low.

The slave controller decodes commands upstream and delivers single-cycle strobes: arm the latch, disarm the latch, commit a status write (with the new protect bits), and commit an array write (with its address). The guard answers with a combinational grant for the same cycle. A denied write is a no-op, and the controller must not start a busy cycle for it. Any commit clears the latch at the clock edge, whether it was granted or not. The latch and the protect bits are also presented as a status byte for readback. The reset input is the power-on/brown-out reset. It is asserted asynchronously and released synchronously inside the block.

Top module: `wprot_guard`

## Requirements
- R1: While reset is held and after it is released, the latch reads 0 and the protect bits read 00, so the status byte reads 0x00.
- R2: An arm strobe with no disarm or commit in the same cycle sets the latch at the next edge. A disarm strobe clears it. Nothing else sets it.
- R3: An array write is granted only while the latch is set.
- R4: Protect-bit encoding: 00 protects nothing, 01 protects 0x3000–0x3FFF, 10 protects 0x2000–0x3FFF, and 11 protects 0x0000–0x3FFF. An array write to a protected address is denied.
- R5: A status write is granted only while the latch is set and the write-protect pin is high. When it is granted, the protect bits take the supplied value at that edge.
- R6: A denied status write, including one refused because the write-protect pin is low, leaves the protect bits unchanged.
- R7: Any array or status commit clears the latch at that edge, whether granted or denied. This clear takes priority over an arm strobe in the same cycle, and that arm strobe has no effect on the commit's own grant.
- R8: When a status write and an array write commit in the same cycle, the array grant is judged against the protect bits held before the update.
- R9: Status byte layout: bit 1 is the latch, bits 3:2 are the protect bits, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wel_set_i | input | 1 | Arm the write enable latch |
| wel_clr_i | input | 1 | Disarm the write enable latch |
| sr_wr_i | input | 1 | Status-register write commit |
| sr_bp_i | input | 2 | Protect bits carried by the status write |
| arr_wr_i | input | 1 | Array write commit |
| addr_i | input | 14 | Target byte address of the array write |
| wp_n_i | input | 1 | Write-protect pin, low freezes the protect bits |
| arr_allow_o | output | 1 | Array write granted this cycle |
| sr_allow_o | output | 1 | Status write granted this cycle |
| wel_o | output | 1 | Write enable latch |
| bp_o | output | 2 | Block-protect bits |
| status_o | output | 8 | Status readback byte |

## Verification
The arm strobe can coincide with a commit. The bench drives both in one cycle, once from a disarmed latch and once from an armed one. It expects the grant to follow the latch value from before the edge, and it expects the latch to end cleared in both cases. A status write can also coincide with an array write. The bench sends both while the region is the top half, raising it to the whole array, and targets address 0x0000. It expects the array grant, because the old region applies, and it expects the new bits to be visible after the edge.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;
  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;

  localparam int BP_W       = 2;
  localparam int STAT_WEL   = 1;
  localparam int STAT_BP_LO = 2;
endpackage

// File: rtl/wpg_rst_sync.sv
`timescale 1ns/1ps
module wpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wpg_wel.sv
`timescale 1ns/1ps
module wpg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic commit_i,
  output logic wel_q
);
  logic wel_d;
  logic wel_en;

  // Clear (explicit or by commit) outranks set.
  always_comb begin
    wel_en = set_i | clr_i | commit_i;
    wel_d  = set_i & ~clr_i & ~commit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end
endmodule

// File: rtl/wpg_bp_reg.sv
`timescale 1ns/1ps
module wpg_bp_reg
  import wpg_pkg::*;
#(
  parameter logic [BP_W-1:0] RST_BP = BP_NONE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [BP_W-1:0] bp_i,
  output logic [BP_W-1:0] bp_q
);
  logic [BP_W-1:0] bp_d;

  always_comb bp_d = bp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bp_q <= RST_BP;
    else if (load_i) bp_q <= bp_d;
  end
endmodule

// File: rtl/wpg_region.sv
`timescale 1ns/1ps
module wpg_region
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};

  always_comb begin
    unique case (bp_e'(bp_i))
      BP_NONE:    hit_o = 1'b0;
      BP_QUARTER: hit_o = (addr_i >= QTR_BASE);
      BP_HALF:    hit_o = (addr_i >= HALF_BASE);
      default:    hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_guard.sv
`timescale 1ns/1ps
module wprot_guard
  import wpg_pkg::*;
#(
  parameter int              ADDR_W      = 14,
  parameter int              STAT_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [BP_W-1:0] RST_BP      = BP_NONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [BP_W-1:0]   sr_bp_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  output logic              arr_allow_o,
  output logic              sr_allow_o,
  output logic              wel_o,
  output logic [BP_W-1:0]   bp_o,
  output logic [STAT_W-1:0] status_o
);
  logic            rst_n_int;
  logic            wel_q;
  logic [BP_W-1:0] bp_q;
  logic            region_hit;
  logic            commit;

  wpg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  wpg_region #(.ADDR_W(ADDR_W)) u_region (
    .bp_i   (bp_q),
    .addr_i (addr_i),
    .hit_o  (region_hit)
  );

  always_comb begin
    commit      = arr_wr_i | sr_wr_i;
    arr_allow_o = arr_wr_i & wel_q & ~region_hit;
    sr_allow_o  = sr_wr_i & wel_q & wp_n_i;
  end

  wpg_wel u_wel (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_i    (wel_set_i),
    .clr_i    (wel_clr_i),
    .commit_i (commit),
    .wel_q    (wel_q)
  );

  wpg_bp_reg #(.RST_BP(RST_BP)) u_bp (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (sr_allow_o),
    .bp_i   (sr_bp_i),
    .bp_q   (bp_q)
  );

  assign wel_o = wel_q;
  assign bp_o  = bp_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == STAT_WEL) begin : g_wel
      assign status_o[i] = wel_q;
    end else if (i >= STAT_BP_LO && i < STAT_BP_LO + BP_W) begin : g_bp
      assign status_o[i] = bp_q[i-STAT_BP_LO];
    end else begin : g_zero
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/wprot_guard_chk.sv
`timescale 1ns/1ps
module wprot_guard_chk #(
  parameter int ADDR_W = 14,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wel_set_i,
  input logic              wel_clr_i,
  input logic              sr_wr_i,
  input logic [1:0]        sr_bp_i,
  input logic              arr_wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wp_n_i,
  input logic              arr_allow_o,
  input logic              sr_allow_o,
  input logic              wel_o,
  input logic [1:0]        bp_o,
  input logic [STAT_W-1:0] status_o
);
  a_r2_only_set_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel_o && !wel_set_i) |=> !wel_o);

  a_r3_arr_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    arr_allow_o |-> (wel_o && arr_wr_i));

  a_r4_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_o == 2'b11) |-> !arr_allow_o);

  a_r4_top_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_o != 2'b00 && addr_i[ADDR_W-1 -: 2] == 2'b11) |-> !arr_allow_o);

  a_r5_sr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sr_allow_o |-> (wel_o && wp_n_i && sr_wr_i));

  a_r5_sr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    sr_allow_o |=> (bp_o == $past(sr_bp_i)));

  a_r6_deny_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_allow_o |=> $stable(bp_o));

  a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_i || sr_wr_i || wel_clr_i) |=> !wel_o);

  a_r9_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] == wel_o) && (status_o[3:2] == bp_o) && !status_o[0]);
endmodule

bind wprot_guard wprot_guard_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wel_set_i   (wel_set_i),
  .wel_clr_i   (wel_clr_i),
  .sr_wr_i     (sr_wr_i),
  .sr_bp_i     (sr_bp_i),
  .arr_wr_i    (arr_wr_i),
  .addr_i      (addr_i),
  .wp_n_i      (wp_n_i),
  .arr_allow_o (arr_allow_o),
  .sr_allow_o  (sr_allow_o),
  .wel_o       (wel_o),
  .bp_o        (bp_o),
  .status_o    (status_o)
);

// File: tb/wprot_guard_bench.sv
`timescale 1ns/1ps
module wprot_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wel_set_i, wel_clr_i, sr_wr_i, arr_wr_i, wp_n_i;
  logic [1:0]  sr_bp_i;
  logic [13:0] addr_i;
  logic        arr_allow_o, sr_allow_o, wel_o;
  logic [1:0]  bp_o;
  logic [7:0]  status_o;

  always #10 clk = ~clk;

  wprot_guard u_wprot_guard (
    .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
    .sr_wr_i(sr_wr_i), .sr_bp_i(sr_bp_i), .arr_wr_i(arr_wr_i), .addr_i(addr_i),
    .wp_n_i(wp_n_i), .arr_allow_o(arr_allow_o), .sr_allow_o(sr_allow_o),
    .wel_o(wel_o), .bp_o(bp_o), .status_o(status_o)
  );

  typedef struct {
    string      tag;
    logic       ea;
    logic       es;
    logic [7:0] est;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  logic       m_wel;
  logic [1:0] m_bp;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic prot(logic [1:0] bp, logic [13:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 14'h3000;
      2'b10:   return a >= 14'h2000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic op(string tag, logic set, logic clr, logic srw, logic [1:0] sbp,
                    logic arw, logic [13:0] a, logic wpn);
    item_t it;
    @(negedge clk); #1;
    wel_set_i = set; wel_clr_i = clr; sr_wr_i = srw; sr_bp_i = sbp;
    arr_wr_i = arw; addr_i = a; wp_n_i = wpn;
    it.tag = tag;
    it.ea  = arw & m_wel & ~prot(m_bp, a);
    it.es  = srw & m_wel & wpn;
    if (it.es) m_bp = sbp;
    if (arw | srw | clr) m_wel = 1'b0;
    else if (set)        m_wel = 1'b1;
    it.est = {4'b0, m_bp, m_wel, 1'b0};
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk); #1;
    wel_set_i = 0; wel_clr_i = 0; sr_wr_i = 0; arr_wr_i = 0;
    sr_bp_i = 0; addr_i = 0; wp_n_i = 1;
  endtask

  task automatic arm();
    op("R2 arm", 1, 0, 0, 2'b00, 0, 14'h0, 1);
  endtask

  // Monitor: grants just before the edge, state just after it.
  initial begin
    forever begin
      item_t it;
      @(negedge clk); #8;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({it.tag, " arr_allow"}, {7'b0, arr_allow_o}, {7'b0, it.ea});
        chk({it.tag, " sr_allow"},  {7'b0, sr_allow_o},  {7'b0, it.es});
        @(posedge clk); #2;
        chk({it.tag, " status"}, status_o, it.est);
        chk({it.tag, " wel/bp"}, {5'b0, bp_o, wel_o}, {5'b0, it.est[3:1]});
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wel_set_i = 0; wel_clr_i = 0; sr_wr_i = 0; arr_wr_i = 0;
    sr_bp_i = 0; addr_i = 0; wp_n_i = 1;
    m_wel = 0; m_bp = 0;
    repeat (3) @(posedge clk);
    #2 chk("R1 status in reset", status_o, 8'h00);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #2 chk("R1 status after reset", status_o, 8'h00);
    chk("R9 reset layout", {5'b0, bp_o, wel_o}, 8'h00);

    op("R3 array write unarmed", 0, 0, 0, 2'b00, 1, 14'h0000, 1);
    arm();
    op("R2 disarm", 0, 1, 0, 2'b00, 0, 14'h0, 1);
    arm();
    op("R3 armed array write", 0, 0, 0, 2'b00, 1, 14'h0100, 1);
    arm();
    op("R5 status write quarter", 0, 0, 1, 2'b01, 0, 14'h0, 1);
    arm();
    op("R4 quarter deny 0x3000", 0, 0, 0, 2'b00, 1, 14'h3000, 1);
    arm();
    op("R4 quarter allow 0x2FFF", 0, 0, 0, 2'b00, 1, 14'h2FFF, 1);
    arm();
    op("R5 status write half", 0, 0, 1, 2'b10, 0, 14'h0, 1);
    arm();
    op("R4 half deny 0x2000", 0, 0, 0, 2'b00, 1, 14'h2000, 1);
    arm();
    op("R4 half allow 0x1FFF", 0, 0, 0, 2'b00, 1, 14'h1FFF, 1);
    arm();
    op("R6 wp low status write", 0, 0, 1, 2'b11, 0, 14'h0, 0);
    op("R5 status write unarmed", 0, 0, 1, 2'b00, 0, 14'h0, 1);
    op("R7 arm with array commit", 1, 0, 0, 2'b00, 1, 14'h0000, 1);
    arm();
    op("R7 arm with status commit", 1, 0, 1, 2'b10, 0, 14'h0, 1);
    arm();
    op("R8 status+array same cycle", 0, 0, 1, 2'b11, 1, 14'h0000, 1);
    arm();
    op("R4 all deny 0x0000", 0, 0, 0, 2'b00, 1, 14'h0000, 1);
    arm();
    op("R5 status write none", 0, 0, 1, 2'b00, 0, 14'h0, 1);
    arm();
    op("R4 none allow 0x3FFF", 0, 0, 0, 2'b00, 1, 14'h3FFF, 1);
    idle();
    repeat (4) @(posedge clk);
    #2 chk("R9 final status", status_o, 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule